// File: doc/BRIEF.md
# Tree-Structured Fair Round-Robin Arbiter

This block picks one winner per cycle among `N_REQ` request lines and returns a one-hot grant in the same cycle. The request lines are split into groups of four adjacent inputs. Each group has a small cell that keeps a rotating pointer and a one-bit "round finished" flag. Above the groups sits a purely combinational tree of four-input nodes. The top node has two or four inputs, depending on whether log2 of the group count is odd. Each node is a parallel-prefix fixed-priority selector over the requests coming up from its children. The acknowledge travels back down the tree, and each node gates its own selection with the acknowledge it receives from its parent.

Only the group cells hold state. A group that has just served its highest pending input marks its round as finished and stops requesting upward. Groups further along then get their turn, even though the upper nodes always favour lower indices. When no unfinished group has work left, a restart condition is broadcast. That restart reopens every group in the same cycle, so the arbiter never idles while a request is pending. Under a static request pattern the result is plain ascending-index round-robin across all inputs. The block suits output ports of an on-chip switch with many inputs.

`N_REQ` must be a power of two and at least four.

Top module: `rr_tree_arbiter`

## Requirements
- R1: After reset, a static set of pending requests is granted in ascending input index, starting from the lowest pending index and wrapping from the highest back to the lowest, with one grant per cycle.
- R2: The grant vector has at most one bit set in every cycle.
- R3: A grant bit is set only where the matching request bit is set in the same cycle.
- R4: The grant vector is non-zero in exactly those cycles in which at least one request is set. This holds in the same cycle, with no cycle of latency, and the grant is zero while reset is held with no request.
- R5: After a change of request pattern and a settling interval of 3K+4 cycles, any K consecutive grants under a static set of K requests contain every requester exactly once.
- R6: A lone pending request is granted in every cycle it is held.
- R7: Group g covers inputs 4g to 4g+3. A group serves its pending inputs in ascending order from its pointer, and once it has served its highest pending input it yields to every other group with pending inputs. For example, with requests {0,1,8} the grants after reset run 0, 1, 8, 0, 1, 8.
- R8: An input raised in a group that has already finished its round waits until every unfinished group's pending inputs are served. For example, after requests {0,4} grant input 0, switching the requests to {1,4} grants input 4 first and then input 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; pointer and round flags update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every pointer to 0 and every round flag |
| req | input | N_REQ | One request bit per input |
| gnt | output | N_REQ | One-hot grant, combinational from `req` and the registered group state |

## Verification
The grant is a function of the current requests and the registered group state. It is therefore due in the same cycle as the request pattern that produces it, while the effect of that grant on pointers and round flags appears only from the next rising edge onward. The bench drives requests just after a falling edge, samples the grant one nanosecond later, and counts exactly one grant per clock period. Expected orders come from an ascending-with-wrap search over the request mask, and the R5 fairness windows are checked as set coverage after a settling interval that is long enough for pointers left over from a previous pattern to realign.

// File: rtl/rr_tree_pkg.sv
package rr_tree_pkg;

    // Radix of the tree and width of one group
    localparam int LEAF_W = 4;
    localparam int PTR_W  = $clog2(LEAF_W);

    // State kept per group of inputs
    typedef struct packed {
        logic [PTR_W-1:0] ptr;   // first index searched next time
        logic             lock;  // group has finished its round
    } leaf_state_t;

    // Number of grouping levels between the groups and the top node
    function automatic int tree_levels(input int nleaf);
        int lv = 0;
        int c  = nleaf;
        while (c > LEAF_W) begin
            c  = c / LEAF_W;
            lv = lv + 1;
        end
        return lv;
    endfunction

    // Node count on a given level (level 0 = group cells)
    function automatic int lvl_cnt(input int nleaf, input int lv);
        int c = nleaf;
        for (int k = 0; k < lv; k++) c = c / LEAF_W;
        return c;
    endfunction

    // Bit offset of a level inside the flattened tree vectors
    function automatic int lvl_off(input int nleaf, input int lv);
        int s = 0;
        for (int k = 0; k < lv; k++) s = s + lvl_cnt(nleaf, k);
        return s;
    endfunction

endpackage

// File: rtl/rrt_prefix_fpa.sv
// Parallel-prefix fixed-priority selector: lowest set index wins,
// result gated by an enable coming from the level above.
module rrt_prefix_fpa #(
    parameter int W = 4
) (
    input  logic [W-1:0] req,
    input  logic         en,
    output logic [W-1:0] gnt
);
    localparam int STG = (W > 1) ? $clog2(W) : 0;

    // pre[s][i]: no request below i within a window of 2^s
    logic [W-1:0] pre [STG+1];

    always_comb begin
        pre[0]    = (~req) << 1;
        pre[0][0] = 1'b1;
        for (int s = 0; s < STG; s++) begin
            for (int i = 0; i < W; i++) begin
                pre[s+1][i] = pre[s][i] &
                              pre[s][(i >= (1 << s)) ? (i - (1 << s)) : i];
            end
        end
        gnt = req & pre[STG] & {W{en}};
    end

endmodule

// File: rtl/rrt_leaf.sv
// Group cell: four inputs, rotating pointer and round-finished flag.
module rrt_leaf
    import rr_tree_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEAF_W-1:0] req,
    input  logic              ack,
    input  logic              restart,
    output logic              open_req,
    output logic              up_req,
    output logic [LEAF_W-1:0] gnt
);
    leaf_state_t st_q, st_d;

    logic [LEAF_W-1:0] upper_req;
    logic [LEAF_W-1:0] pick_upper;
    logic [LEAF_W-1:0] pick_any;
    logic [LEAF_W-1:0] cand;
    logic [LEAF_W-1:0] higher;
    logic              any_req;
    logic              last;

    // requests at or above the pointer
    always_comb upper_req = req & ~((LEAF_W'(1) << st_q.ptr) - LEAF_W'(1));

    rrt_prefix_fpa #(.W(LEAF_W)) u_sel_upper (
        .req (upper_req),
        .en  (1'b1),
        .gnt (pick_upper)
    );

    rrt_prefix_fpa #(.W(LEAF_W)) u_sel_wrap (
        .req (req),
        .en  (1'b1),
        .gnt (pick_any)
    );

    always_comb begin
        any_req  = |req;
        cand     = (|upper_req) ? pick_upper : pick_any;
        higher   = req & ~(cand | (cand - LEAF_W'(1)));
        last     = ~|higher;
        open_req = any_req & ~st_q.lock;
        up_req   = any_req & (~st_q.lock | restart);
        gnt      = cand & {LEAF_W{ack}};

        st_d = st_q;
        if (ack && any_req) begin
            for (int i = 0; i < LEAF_W; i++) begin
                if (cand[i]) st_d.ptr = (i == LEAF_W - 1) ? '0 : PTR_W'(i + 1);
            end
        end
        if (restart)     st_d.lock = 1'b0;
        if (ack && last) st_d.lock = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rrt_upper.sv
// Stateless selection tree above the group cells.
module rrt_upper
    import rr_tree_pkg::*;
#(
    parameter int N_LEAF = 16
) (
    input  logic [N_LEAF-1:0] leaf_req,
    output logic [N_LEAF-1:0] leaf_ack
);
    localparam int LV       = tree_levels(N_LEAF);
    localparam int TOT      = lvl_off(N_LEAF, LV + 1);
    localparam int ROOT_W   = lvl_cnt(N_LEAF, LV);
    localparam int ROOT_OFF = lvl_off(N_LEAF, LV);

    logic [TOT-1:0] t_req;
    logic [TOT-1:0] t_ack;

    assign t_req[N_LEAF-1:0] = leaf_req;
    assign leaf_ack          = t_ack[N_LEAF-1:0];

    generate
        for (genvar l = 1; l <= LV; l++) begin : g_lvl
            localparam int CNT   = lvl_cnt(N_LEAF, l);
            localparam int OFF   = lvl_off(N_LEAF, l);
            localparam int OFF_C = lvl_off(N_LEAF, l - 1);
            for (genvar g = 0; g < CNT; g++) begin : g_node
                assign t_req[OFF + g] = |t_req[OFF_C + g*LEAF_W +: LEAF_W];
                rrt_prefix_fpa #(.W(LEAF_W)) u_node (
                    .req (t_req[OFF_C + g*LEAF_W +: LEAF_W]),
                    .en  (t_ack[OFF + g]),
                    .gnt (t_ack[OFF_C + g*LEAF_W +: LEAF_W])
                );
            end
        end
    endgenerate

    // top node: two or four inputs (one when there is a single group)
    rrt_prefix_fpa #(.W(ROOT_W)) u_root (
        .req (t_req[ROOT_OFF +: ROOT_W]),
        .en  (1'b1),
        .gnt (t_ack[ROOT_OFF +: ROOT_W])
    );

endmodule

// File: rtl/rr_tree_arbiter.sv
module rr_tree_arbiter
    import rr_tree_pkg::*;
#(
    parameter int N_REQ = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt
);
    localparam int N_LEAF = N_REQ / LEAF_W;

    logic [N_LEAF-1:0] open_v;
    logic [N_LEAF-1:0] up_v;
    logic [N_LEAF-1:0] ack_v;
    logic              restart;

    // no unfinished group has work: reopen all groups this cycle
    assign restart = ~|open_v;

    generate
        for (genvar g = 0; g < N_LEAF; g++) begin : g_leaf
            rrt_leaf u_leaf (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (req[g*LEAF_W +: LEAF_W]),
                .ack      (ack_v[g]),
                .restart  (restart),
                .open_req (open_v[g]),
                .up_req   (up_v[g]),
                .gnt      (gnt[g*LEAF_W +: LEAF_W])
            );
        end
    endgenerate

    rrt_upper #(.N_LEAF(N_LEAF)) u_upper (
        .leaf_req (up_v),
        .leaf_ack (ack_v)
    );

endmodule

// File: rtl/rr_tree_arbiter_chk.sv
module rr_tree_arbiter_chk #(
    parameter int N_REQ = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req,
    input logic [N_REQ-1:0] gnt
);
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_grant_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & ~req) == '0));

    p_busy_grants_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));

    p_idle_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (gnt == '0));

    p_lone_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req) == 1) |-> (gnt == req));

endmodule

bind rr_tree_arbiter rr_tree_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
);

// File: tb/sim_rr_tree_arbiter.sv
`timescale 1ns/1ps
module sim_rr_tree_arbiter;
    localparam int N = 32;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req   = '0;
    logic [N-1:0] gnt;
    int           n_chk  = 0;
    int           n_fail = 0;
    logic [31:0]  lfsr   = 32'h1d87_2b41;

    always #2.5 clk = ~clk;

    rr_tree_arbiter #(.N_REQ(N)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // next requester strictly above prev, wrapping
    function automatic logic [N-1:0] next_up(input logic [N-1:0] mask, input int prev);
        logic [N-1:0] one = 1;
        for (int d = 1; d <= N; d++) begin
            int idx = (prev + d) % N;
            if (mask[idx]) return one << idx;
        end
        return '0;
    endfunction

    function automatic logic [31:0] shuffle(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic drive_sample(input logic [N-1:0] mask, output logic [N-1:0] g);
        @(negedge clk);
        req = mask;
        #1;
        g = gnt;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req   = '0;
        rst_n = 1'b0;
        #1;
        check(gnt == '0, "R4 grant zero in reset", gnt, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_from_reset(input logic [N-1:0] mask, input string tag);
        logic [N-1:0] g, e;
        int prev = -1;
        int k = $countones(mask);
        do_reset();
        for (int c = 0; c < 2*k; c++) begin
            drive_sample(mask, g);
            e = next_up(mask, prev);
            check(g == e, tag, g, e);
            prev = $clog2(e);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", gnt, req);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] g, seen, m, e;
        int k;

        // R1 / R7: exact order from reset
        run_from_reset(32'h0000_1008, "R1 ascending order groups 0 and 3");
        run_from_reset(32'h0000_0103, "R7 two in group 0 one in group 2");
        run_from_reset(32'h0000_0026, "R7 two in group 0 one in group 1");
        run_from_reset(32'hFFFF_FFFF, "R1 all inputs requesting");
        run_from_reset(32'h8000_0001, "R1 lowest and highest");
        for (int r = 0; r < 20; r++) begin
            lfsr = shuffle(lfsr);
            m = lfsr & (lfsr >> 5);
            if (m == '0) m = 32'h0000_0400;
            run_from_reset(m, "R1 ascending order random set");
        end

        // R6: lone requests
        do_reset();
        for (int b = 0; b < N; b += 7) begin
            e = '0;
            e[b] = 1'b1;
            for (int c = 0; c < 4; c++) begin
                drive_sample(e, g);
                check(g == e, "R6 lone request every cycle", g, e);
            end
        end

        // R8: finished group waits for others
        do_reset();
        drive_sample(32'h0000_0011, g);
        check(g == 32'h0000_0001, "R8 first grant", g, 32'h0000_0001);
        drive_sample(32'h0000_0012, g);
        check(g == 32'h0000_0010, "R8 finished group yields", g, 32'h0000_0010);
        drive_sample(32'h0000_0012, g);
        check(g == 32'h0000_0002, "R8 served after restart", g, 32'h0000_0002);

        // R5: pattern changes without reset, windowed fairness
        for (int p = 0; p < 40; p++) begin
            lfsr = shuffle(lfsr);
            case (p % 3)
                0:       m = lfsr & (lfsr >> 7);
                1:       m = lfsr;
                default: m = lfsr & (lfsr >> 3) & (lfsr >> 11);
            endcase
            if (m == '0) m = 32'h0001_0000;
            k = $countones(m);
            if (p % 5 == 0) begin
                drive_sample('0, g);
                check(g == '0, "R4 no request no grant", g, '0);
            end
            for (int c = 0; c < 3*k + 4; c++) begin
                drive_sample(m, g);
                check($onehot(g) && ((g & ~m) == '0),
                      "R2 R3 R4 one-hot grant inside request set", g, m);
            end
            for (int w = 0; w < 2; w++) begin
                seen = '0;
                for (int c = 0; c < k; c++) begin
                    drive_sample(m, g);
                    seen = seen | g;
                end
                check(seen == m, "R5 window covers every requester", seen, m);
            end
        end

        drive_sample('0, g);
        check(g == '0, "R4 idle at end", g, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule